// File: doc/BRIEF.md
# Prioritized Vector Interrupt Controller

This block holds interrupt state for one processor as three 256-bit vector sets: pending requests, vectors in service, and the trigger mode of each vector. It also holds a task-priority register and a spurious-vector register. The spurious-vector register contains the software enable. A source raises a vector on the request port. The block compares the priority class (vector bits 7:4) of the highest pending request with a processor priority. The processor priority is derived from the task priority and the highest vector in service. When a request wins, the block raises the pending line.

The processor acknowledges with a one-cycle strobe. While the strobe is high, the block returns a result kind and a vector combinationally. On the clock edge that ends the strobe, a delivered vector moves from the request set to the in-service set. The end-of-interrupt strobe retires the highest vector in service. If that vector was level-triggered, the block emits a broadcast strobe with the vector so that the source can re-arm, unless broadcast suppression is set.

Top module: `pvic_ctrl`

## Requirements
- R1: The request chosen for delivery is the highest-numbered set bit of the request set, wherever it lies among the 32-bit words.
- R2: `proc_prio` equals the task-priority register when its class (bits 7:4) is greater than or equal to the class of the highest in-service vector. Otherwise it is that in-service class followed by four zero bits. An empty in-service set counts as class 0.
- R3: `irq_pending` is high exactly when the software enable is set, a request exists, and either `proc_prio` is zero or the chosen request's class is strictly greater than the class of `proc_prio`.
- R4: While `ack_strobe` is high and a deliverable request exists, `ack_kind` is 1 and `ack_vector` is that request. At the edge, its request bit clears and its in-service bit sets.
- R5: When `ack_strobe` is high with the enable set and requests present but none deliverable, `ack_kind` is 2 and `ack_vector` is the low 8 bits of the spurious register, and no set changes. With no request at all, or with no strobe, `ack_kind` is 0 and `ack_vector` is 0.
- R6: A request at the edge sets its request bit and writes its trigger bit: 1 when `req_level` is 1 (level), 0 when it is 0 (edge). A later edge request for the same vector therefore clears the level mark.
- R7: `eoi_strobe` clears the highest in-service bit at the edge. `eoi_bcast` is high during the strobe, with `eoi_bcast_vec` set to that vector, when its trigger bit is 1 and the suppression bit is 0. With an empty in-service set the strobe has no effect.
- R8: A spurious-register write keeps `spur_wdata` bits 7:0 (vector), bit 8 (software enable) and bit 12 (broadcast suppression), and drops bits 11:9. While the enable is 0, `irq_pending` stays low and acknowledges return kind 0.
- R9: `tpr_wr` stores all 8 bits of `tpr_wdata`. `tpr_cls_wr` stores `{tpr_cls, 4'b0000}`.
- R10: A request and an acknowledge of the same vector in one cycle leave the request bit set, while the in-service bit is also set.
- R11: After reset all three sets are empty, the task priority is 0, and the spurious register holds vector 0xFF with enable and suppression clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Raise the vector on `req_vec` this cycle |
| req_vec | input | 8 | Vector being requested |
| req_level | input | 1 | Trigger mode of the request, 1 level, 0 edge |
| ack_strobe | input | 1 | Processor acknowledge |
| eoi_strobe | input | 1 | End of interrupt |
| tpr_wr | input | 1 | Write the full task-priority value |
| tpr_wdata | input | 8 | Task-priority value |
| tpr_cls_wr | input | 1 | Write a task-priority class |
| tpr_cls | input | 4 | Class written to task-priority bits 7:4 |
| spur_wr | input | 1 | Write the spurious register |
| spur_wdata | input | 13 | Spurious register data (7:0 vector, 8 enable, 12 suppression) |
| irq_pending | output | 1 | A deliverable request exists and the block is enabled |
| ack_kind | output | 2 | 0 none, 1 vector, 2 spurious |
| ack_vector | output | 8 | Vector returned to an acknowledge |
| proc_prio | output | 8 | Current processor priority |
| eoi_bcast | output | 1 | Level-triggered vector retired |
| eoi_bcast_vec | output | 8 | Vector carried by the broadcast |

## Verification
The assertions check the following on every cycle:
- the selected request is the topmost set bit;
- the processor priority never falls below the task priority and has either that value or a bare class;
- the pending line is never raised for a request the priority blocks, or while disabled;
- acknowledge, request and end-of-interrupt move exactly the bits they name.

Only the bench's scenarios can show the following:
- the exact value returned for each of the 256 vectors;
- the full task-class by request-class gating table;
- nested servicing, where the order of retirement changes later deliverability;
- a request whose trigger mark is rewritten from level to edge;
- the effect of the dropped spurious-register bits.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned CLS_W     = 4;
  localparam int unsigned SPUR_IN_W = 13;
  localparam int unsigned EN_BIT    = 8;
  localparam int unsigned SUPP_BIT  = 12;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [CLS_W-1:0] cls_t;

  typedef enum logic [1:0] {
    ACK_NONE = 2'd0,
    ACK_VEC  = 2'd1,
    ACK_SPUR = 2'd2
  } ack_kind_e;

  function automatic cls_t class_of(vec_t v);
    return v[VEC_W-1 -: CLS_W];
  endfunction

  // Processor priority from task priority and top in-service vector.
  function automatic vec_t proc_prio_f(vec_t tpr, logic isr_any, vec_t isr_top);
    cls_t ic;
    ic = isr_any ? class_of(isr_top) : '0;
    if (class_of(tpr) >= ic) return tpr;
    return {ic, {(VEC_W-CLS_W){1'b0}}};
  endfunction

  // A request passes the gate when priority is zero or its class is above.
  function automatic logic deliverable_f(vec_t req, vec_t ppr);
    return (ppr == '0) || (class_of(req) > class_of(ppr));
  endfunction
endpackage

// File: rtl/pvic_top_find.sv
module pvic_top_find #(
  parameter int unsigned N      = 256,
  parameter int unsigned WORD_W = 32
) (
  input  logic [N-1:0]         bits,
  output logic                 found,
  output logic [$clog2(N)-1:0] idx
);
  localparam int unsigned IDX_W     = $clog2(N);
  localparam int unsigned BIT_W     = $clog2(WORD_W);
  localparam int unsigned NUM_WORDS = N / WORD_W;

  function automatic logic [BIT_W-1:0] hi_in_word(logic [WORD_W-1:0] w);
    logic [BIT_W-1:0] r;
    r = '0;
    for (int unsigned j = 0; j < WORD_W; j++) begin
      if (w[j]) r = BIT_W'(j);
    end
    return r;
  endfunction

  logic [NUM_WORDS-1:0] word_any;
  logic [BIT_W-1:0]     word_hi [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    assign word_any[g] = |bits[g*WORD_W +: WORD_W];
    assign word_hi[g]  = hi_in_word(bits[g*WORD_W +: WORD_W]);
  end

  // Later (higher) words override earlier ones: top word wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int unsigned w = 0; w < NUM_WORDS; w++) begin
      if (word_any[w]) begin
        found = 1'b1;
        idx   = (IDX_W'(w) << BIT_W) | IDX_W'(word_hi[w]);
      end
    end
  end
endmodule

// File: rtl/pvic_bitset.sv
module pvic_bitset #(
  parameter int unsigned N = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_idx,
  input  logic                 wr_val,
  input  logic                 clr_en,
  input  logic [$clog2(N)-1:0] clr_idx,
  output logic [N-1:0]         bits
);
  localparam int unsigned IDX_W = $clog2(N);

  logic [N-1:0] wr_hit, clr_hit;

  for (genvar b = 0; b < N; b++) begin : g_dec
    assign wr_hit[b]  = wr_en  && (wr_idx  == IDX_W'(b));
    assign clr_hit[b] = clr_en && (clr_idx == IDX_W'(b));
  end

  // A write takes precedence over a clear of the same bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0;
    end else begin
      for (int unsigned b = 0; b < N; b++) begin
        if (wr_hit[b])       bits[b] <= wr_val;
        else if (clr_hit[b]) bits[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pvic_ctrl.sv
module pvic_ctrl
  import pvic_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [7:0]           req_vec,
  input  logic                 req_level,
  input  logic                 ack_strobe,
  input  logic                 eoi_strobe,
  input  logic                 tpr_wr,
  input  logic [7:0]           tpr_wdata,
  input  logic                 tpr_cls_wr,
  input  logic [3:0]           tpr_cls,
  input  logic                 spur_wr,
  input  logic [12:0]          spur_wdata,
  output logic                 irq_pending,
  output logic [1:0]           ack_kind,
  output logic [7:0]           ack_vector,
  output logic [7:0]           proc_prio,
  output logic                 eoi_bcast,
  output logic [7:0]           eoi_bcast_vec
);
  localparam int unsigned NUM_VEC = 1 << VEC_W;

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  vec_t tpr_q, spur_vec_q;
  logic sw_enable, eoi_supp_q;

  logic req_any, isr_any;
  vec_t req_top_vec, isr_top_vec;
  vec_t ppr;
  logic top_deliverable, ack_take, ack_spur, eoi_take;
  ack_kind_e kind;

  pvic_top_find #(.N(NUM_VEC), .WORD_W(WORD_W)) u_find_req (
    .bits(irr_q), .found(req_any), .idx(req_top_vec));

  pvic_top_find #(.N(NUM_VEC), .WORD_W(WORD_W)) u_find_isr (
    .bits(isr_q), .found(isr_any), .idx(isr_top_vec));

  assign ppr             = proc_prio_f(tpr_q, isr_any, isr_top_vec);
  assign top_deliverable = req_any && deliverable_f(req_top_vec, ppr);
  assign ack_take        = ack_strobe && sw_enable && top_deliverable;
  assign ack_spur        = ack_strobe && sw_enable && req_any && !top_deliverable;
  assign eoi_take        = eoi_strobe && isr_any;

  always_comb begin
    if (ack_take)      kind = ACK_VEC;
    else if (ack_spur) kind = ACK_SPUR;
    else               kind = ACK_NONE;
  end

  assign irq_pending   = sw_enable && top_deliverable;
  assign ack_kind      = kind;
  assign ack_vector    = ack_take ? req_top_vec : (ack_spur ? spur_vec_q : '0);
  assign proc_prio     = ppr;
  assign eoi_bcast     = eoi_take && tmr_q[isr_top_vec] && !eoi_supp_q;
  assign eoi_bcast_vec = eoi_bcast ? isr_top_vec : '0;

  pvic_bitset #(.N(NUM_VEC)) u_irr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(req_valid), .wr_idx(req_vec), .wr_val(1'b1),
    .clr_en(ack_take), .clr_idx(req_top_vec),
    .bits(irr_q));

  pvic_bitset #(.N(NUM_VEC)) u_isr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ack_take), .wr_idx(req_top_vec), .wr_val(1'b1),
    .clr_en(eoi_take), .clr_idx(isr_top_vec),
    .bits(isr_q));

  pvic_bitset #(.N(NUM_VEC)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(req_valid), .wr_idx(req_vec), .wr_val(req_level),
    .clr_en(1'b0), .clr_idx('0),
    .bits(tmr_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr_q <= '0;
    end else if (tpr_wr) begin
      tpr_q <= tpr_wdata;
    end else if (tpr_cls_wr) begin
      tpr_q <= {tpr_cls, {(VEC_W-CLS_W){1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spur_vec_q <= '1;
      sw_enable  <= 1'b0;
      eoi_supp_q <= 1'b0;
    end else if (spur_wr) begin
      spur_vec_q <= spur_wdata[VEC_W-1:0];
      sw_enable  <= spur_wdata[EN_BIT];
      eoi_supp_q <= spur_wdata[SUPP_BIT];
    end
  end
endmodule

// File: rtl/pvic_ctrl_chk.sv
module pvic_ctrl_chk
  import pvic_pkg::*;
(
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic [7:0]   req_vec,
  input logic         req_level,
  input logic         ack_strobe,
  input logic         eoi_strobe,
  input logic         irq_pending,
  input logic [1:0]   ack_kind,
  input logic [7:0]   ack_vector,
  input logic [7:0]   proc_prio,
  input logic         eoi_bcast,
  input logic [7:0]   eoi_bcast_vec,
  input logic [255:0] irr_q,
  input logic [255:0] isr_q,
  input logic [255:0] tmr_q,
  input logic [7:0]   tpr_q,
  input logic         sw_enable,
  input logic         req_any,
  input logic [7:0]   req_top_vec
);
  p_top_is_highest_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_any |-> ((irr_q >> req_top_vec) == 256'd1));

  p_ppr_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_prio >= tpr_q) && (proc_prio == tpr_q || proc_prio[3:0] == 4'h0));

  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (req_any && (proc_prio == 8'h00 || req_top_vec[7:4] > proc_prio[7:4])));

  p_ack_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_strobe && ack_kind == ACK_VEC) |=>
      (isr_q[$past(ack_vector)] &&
       (irr_q[$past(ack_vector)] == ($past(req_valid) && $past(req_vec) == $past(ack_vector)))));

  p_spur_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_strobe && ack_kind == ACK_SPUR && !eoi_strobe && !req_valid) |=>
      ($stable(isr_q) && $stable(irr_q)));

  p_req_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (irr_q[$past(req_vec)] && tmr_q[$past(req_vec)] == $past(req_level)));

  p_bcast_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast |-> (eoi_strobe && tmr_q[eoi_bcast_vec] && isr_q[eoi_bcast_vec]));

  p_bcast_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_bcast && !(ack_strobe && ack_kind == ACK_VEC && ack_vector == eoi_bcast_vec)) |=>
      !isr_q[$past(eoi_bcast_vec)]);

  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_enable |-> (!irq_pending && ack_kind == ACK_NONE));
endmodule

bind pvic_ctrl pvic_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
  .req_level(req_level), .ack_strobe(ack_strobe), .eoi_strobe(eoi_strobe),
  .irq_pending(irq_pending), .ack_kind(ack_kind), .ack_vector(ack_vector),
  .proc_prio(proc_prio), .eoi_bcast(eoi_bcast), .eoi_bcast_vec(eoi_bcast_vec),
  .irr_q(irr_q), .isr_q(isr_q), .tmr_q(tmr_q), .tpr_q(tpr_q),
  .sw_enable(sw_enable), .req_any(req_any), .req_top_vec(req_top_vec));

// File: tb/pvic_ctrl_tb.sv
module pvic_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_level = 0, ack_strobe = 0, eoi_strobe = 0;
  logic [7:0] req_vec = '0, tpr_wdata = '0;
  logic tpr_wr = 0, tpr_cls_wr = 0, spur_wr = 0;
  logic [3:0] tpr_cls = '0;
  logic [12:0] spur_wdata = '0;
  logic irq_pending, eoi_bcast;
  logic [1:0] ack_kind;
  logic [7:0] ack_vector, proc_prio, eoi_bcast_vec;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  // Reference model state
  bit [255:0] m_irr, m_isr, m_tmr;
  bit [7:0] m_tpr = 8'h00;
  bit [7:0] m_spv = 8'hFF;
  bit m_en = 1'b0;
  bit m_supp = 1'b0;

  always #2 clk = ~clk;

  pvic_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
    .req_level(req_level), .ack_strobe(ack_strobe), .eoi_strobe(eoi_strobe),
    .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata), .tpr_cls_wr(tpr_cls_wr),
    .tpr_cls(tpr_cls), .spur_wr(spur_wr), .spur_wdata(spur_wdata),
    .irq_pending(irq_pending), .ack_kind(ack_kind), .ack_vector(ack_vector),
    .proc_prio(proc_prio), .eoi_bcast(eoi_bcast), .eoi_bcast_vec(eoi_bcast_vec));

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Scan from the top vector down; first hit is the highest.
  task automatic m_top(input bit [255:0] s, output bit any, output bit [7:0] top);
    any = 0;
    top = 0;
    for (int i = 255; i >= 0; i--) begin
      if (s[i] && !any) begin
        any = 1;
        top = 8'(i);
      end
    end
  endtask

  function automatic bit [7:0] m_ppr(input bit ia, input bit [7:0] it);
    int tc, ic;
    tc = m_tpr / 16;
    ic = ia ? it / 16 : 0;
    return (tc >= ic) ? m_tpr : 8'(ic * 16);
  endfunction

  task automatic op(input bit rq, input bit [7:0] rv, input bit rl,
                    input bit ak, input bit eo);
    bit ra, ia, dl, eb;
    bit [7:0] rt, it, pp, ev;
    bit [1:0] ek;
    req_valid = rq; req_vec = rv; req_level = rl;
    ack_strobe = ak; eoi_strobe = eo;
    @(negedge clk);
    m_top(m_irr, ra, rt);
    m_top(m_isr, ia, it);
    pp = m_ppr(ia, it);
    dl = ra && (pp == 0 || (rt / 16) > (pp / 16));
    ek = 0;
    ev = 0;
    if (ak && m_en) begin
      if (dl) begin ek = 1; ev = rt; end
      else if (ra) begin ek = 2; ev = m_spv; end
    end
    eb = eo && ia && m_tmr[it] && !m_supp;
    chk("R2", "proc_prio", proc_prio, pp);
    chk(m_en ? "R3" : "R8", "irq_pending", irq_pending, m_en && dl);
    chk(ek == 2 ? "R5" : "R4", "ack_kind", ack_kind, ek);
    chk(ek == 2 ? "R5" : "R1", "ack_vector", ack_vector, ev);
    chk("R7", "eoi_bcast", eoi_bcast, eb);
    chk("R7", "eoi_bcast_vec", eoi_bcast_vec, eb ? it : 8'h00);
    @(posedge clk);
    #1;
    req_valid = 0; ack_strobe = 0; eoi_strobe = 0;
    if (ek == 1) m_irr[rt] = 0;
    if (rq) begin m_irr[rv] = 1; m_tmr[rv] = rl; end
    if (eo && ia) m_isr[it] = 0;
    if (ek == 1) m_isr[rt] = 1;
  endtask

  task automatic wr_tpr(input bit [7:0] v);
    tpr_wr = 1; tpr_wdata = v;
    @(posedge clk); #1;
    tpr_wr = 0;
    m_tpr = v;
  endtask

  task automatic wr_cls(input bit [3:0] c);
    tpr_cls_wr = 1; tpr_cls = c;
    @(posedge clk); #1;
    tpr_cls_wr = 0;
    m_tpr = {c, 4'h0};
  endtask

  task automatic wr_spur(input bit [12:0] d);
    spur_wr = 1; spur_wdata = d;
    @(posedge clk); #1;
    spur_wr = 0;
    m_spv = d[7:0]; m_en = d[8]; m_supp = d[12];
  endtask

  initial begin
    // R11: reset state
    @(negedge clk);
    chk("R11", "irq_pending", irq_pending, 0);
    chk("R11", "proc_prio", proc_prio, 0);
    chk("R11", "eoi_bcast", eoi_bcast, 0);
    @(posedge clk); #1;
    rst_n = 1;
    op(0, 0, 0, 1, 1);

    // R8: disabled block hides a request, then enable
    op(1, 8'h40, 1, 0, 0);
    op(0, 0, 0, 1, 0);
    wr_spur(13'h013F);
    op(0, 0, 0, 1, 0);
    op(0, 0, 0, 0, 1);

    // R4 R6 R7: every vector, alternating trigger mode
    for (int v = 0; v < 256; v++) begin
      op(1, 8'(v), v[0], 0, 0);
      op(0, 0, 0, 1, 0);
      op(0, 0, 0, 0, 1);
    end

    // R1: highest across words; R5 blocked by in-service class
    op(1, 8'h03, 0, 0, 0);
    op(1, 8'h47, 1, 0, 0);
    op(1, 8'h9A, 0, 0, 0);
    op(1, 8'h21, 0, 0, 0);
    op(0, 0, 0, 1, 0);
    op(0, 0, 0, 1, 0);
    for (int k = 0; k < 4; k++) begin
      op(0, 0, 0, 0, 1);
      op(0, 0, 0, 1, 0);
    end
    op(0, 0, 0, 0, 1);

    // R3 R9: task-class by request-class gating table
    for (int t = 0; t < 16; t++) begin
      for (int c = 0; c < 16; c++) begin
        wr_cls(4'(t));
        op(1, 8'(c * 16 + 7), 0, 0, 0);
        op(0, 0, 0, 1, 0);
        wr_cls(4'h0);
        op(0, 0, 0, 1, 0);
        op(0, 0, 0, 0, 1);
      end
    end

    // R2 R9: nested servicing with full task-priority writes
    op(1, 8'h80, 0, 0, 0);
    op(0, 0, 0, 1, 0);
    wr_tpr(8'h85);
    op(0, 0, 0, 0, 0);
    wr_tpr(8'h7F);
    op(1, 8'h8F, 0, 0, 0);
    op(0, 0, 0, 1, 0);
    op(1, 8'h9F, 1, 0, 0);
    op(0, 0, 0, 1, 0);
    op(0, 0, 0, 0, 1);
    op(0, 0, 0, 0, 1);
    op(0, 0, 0, 1, 0);
    op(0, 0, 0, 0, 1);
    wr_tpr(8'h00);

    // R7 R8: suppression bit, then dropped bits 11:9
    wr_spur(13'h113F);
    op(1, 8'h55, 1, 0, 0);
    op(0, 0, 0, 1, 0);
    op(0, 0, 0, 0, 1);
    wr_spur(13'h0F3F);
    op(1, 8'h55, 1, 0, 0);
    op(0, 0, 0, 1, 0);
    op(0, 0, 0, 0, 1);

    // R6: level mark rewritten by an edge request
    op(1, 8'h60, 1, 0, 0);
    op(1, 8'h60, 0, 0, 0);
    op(0, 0, 0, 1, 0);
    op(0, 0, 0, 0, 1);

    // R10: request and acknowledge of one vector together
    op(1, 8'h70, 0, 0, 0);
    op(1, 8'h70, 0, 1, 0);
    op(0, 0, 0, 0, 0);
    op(0, 0, 0, 0, 1);
    op(0, 0, 0, 1, 0);
    op(0, 0, 0, 0, 1);

    // R8: clearing the enable with a request waiting
    op(1, 8'hC3, 0, 0, 0);
    wr_spur(13'h00FF);
    op(0, 0, 0, 1, 0);
    wr_spur(13'h01FF);
    op(0, 0, 0, 1, 0);
    op(0, 0, 0, 0, 1);

    summary();
    $finish;
  end
endmodule